// File: doc/BRIEF.md
# DMA channel progress and event tracker

This block follows the progress of a single DMA channel and raises its interrupt flags. It keeps a source pointer and a destination pointer, each advancing by one byte on every transfer beat. It also keeps a cell byte counter and a block byte counter. These are compared against the programmed source size, destination size and cell size. Crossing a half point, an end point, a cell boundary or a block boundary raises a sticky flag.

Beside the beat strobe, the block takes a pattern-match strobe that ends the block early. It takes an interrupt number with a valid strobe; a number equal to the programmed abort number halts the channel. It also takes two address-error reports. Eight sticky flags, each cleared by writing a 1 to its bit, are masked by eight enables and combined into one interrupt request. The data mover, channel arbitration and pattern comparison sit outside the block. Only their strobes enter it.

Top module: `dma_chan_tracker`

## Requirements
- R1: While `rst_ni` is low, and after it is released, flags, both pointers and `irq_o` are zero.
- R2: Flag bits: 7 source done, 6 source half, 5 destination done, 4 destination half, 3 block complete, 2 cell complete, 1 abort, 0 address error. A flag stays set until a 1 is written to its bit on `flag_clr_i`. A set event in the same cycle as a clear wins.
- R3: A beat on an active channel advances `src_ptr_o` by one. The beat that brings it to `src_size_i` (sizes are 1 or more) sets bit 7 and wraps the pointer to 0.
- R4: Bit 6 sets when the source pointer reaches floor(`src_size_i`/2). Bit 4 sets when the destination pointer reaches floor(`dst_size_i`/2). A size of 1 gives no half event.
- R5: A beat bringing `dst_ptr_o` to `dst_size_i` sets bit 5 and wraps the pointer to 0.
- R6: After max(`src_size_i`, `dst_size_i`) beats, bit 3 sets. On that beat both pointers, the cell counter and the block counter return to 0.
- R7: A pattern match on an active channel sets bit 3 and resets all counters. A beat in the same cycle is dropped.
- R8: Bit 2 sets on every `cell_size_i`-th beat since the last block boundary.
- R9: A valid interrupt number equal to `abort_num_i` on an active channel sets bit 1 and resets all counters. It also drops `active_o`. Beats, pattern matches and interrupt numbers are then ignored until `chan_en_i` goes low. An abort in the same cycle as a pattern match or a beat wins over both.
- R10: Bit 0 sets in every cycle in which `src_addr_err_i` or `dst_addr_err_i` is high.
- R11: While `chan_en_i` is low, all counters are held at 0, the abort halt is released and no beat is counted.
- R12: `irq_o` is the OR of `flags_o & flag_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable |
| src_size_i | input | SZW | Source size in bytes |
| dst_size_i | input | SZW | Destination size in bytes |
| cell_size_i | input | SZW | Cell size in bytes |
| abort_num_i | input | IRQW | Interrupt number that aborts the channel |
| beat_i | input | 1 | One byte moved this cycle |
| pat_match_i | input | 1 | Pattern match seen |
| irq_valid_i | input | 1 | `irq_num_i` is valid |
| irq_num_i | input | IRQW | Incoming interrupt number |
| src_addr_err_i | input | 1 | Source address reported invalid |
| dst_addr_err_i | input | 1 | Destination address reported invalid |
| flag_clr_i | input | 8 | Write-1-to-clear strobe per flag |
| flag_en_i | input | 8 | Interrupt enable per flag |
| flags_o | output | 8 | Sticky flags |
| irq_o | output | 1 | Combined interrupt request |
| active_o | output | 1 | Channel enabled and not aborted |
| src_ptr_o | output | SZW | Source pointer |
| dst_ptr_o | output | SZW | Destination pointer |

## Verification
On every cycle, the assertions check several things. Each counter steps by one or returns to zero. A set event always lands in the flags, and flags not set hold until cleared. An abort drops `active_o` and leaves the pointers frozen at zero. An address error always raises bit 0. Only the bench scenarios can show that flags rise at the right beat counts. This covers the half points at floor(size/2), the silence for size 1, block length taken from the larger size, cell boundaries restarting at a block, and the early end on a pattern match. The bench compares against a reference model in random episodes mixed with directed corner cases.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;
  localparam int unsigned NFLAG    = 8;
  localparam int unsigned F_SRC_DN = 7;
  localparam int unsigned F_SRC_HF = 6;
  localparam int unsigned F_DST_DN = 5;
  localparam int unsigned F_DST_HF = 4;
  localparam int unsigned F_BLK    = 3;
  localparam int unsigned F_CELL   = 2;
  localparam int unsigned F_ABORT  = 1;
  localparam int unsigned F_ADDR   = 0;
  // counter slots
  localparam int unsigned C_SRC  = 0;
  localparam int unsigned C_DST  = 1;
  localparam int unsigned C_CELL = 2;
  localparam int unsigned C_BLK  = 3;
  localparam int unsigned NCNT   = 4;
  typedef logic [NFLAG-1:0] flags_t;
endpackage

// File: rtl/dma_trk_cnt.sv
module dma_trk_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o,
  output logic         half_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;
  logic [W-1:0] half_lim;

  assign nxt      = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign half_lim = limit_i >> 1;
  assign done_o   = step_i && (nxt == {1'b0, limit_i});
  assign half_o   = step_i && (half_lim != '0) && (nxt == {1'b0, half_lim});
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= done_o ? '0 : nxt[W-1:0];
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i && !done_o |=> cnt_o == W'($past(cnt_o) + 1'b1));
  // R3
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cnt_o == '0);
  // R6
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/dma_trk_flags.sv
module dma_trk_flags
  import dma_trk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t set_i,
  input  flags_t clr_i,
  input  flags_t en_i,
  output flags_t flags_o,
  output logic   irq_o
);
  flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  // R2
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i != '0 |=> (flags_o & $past(set_i)) == $past(set_i));
  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flags_o & ~$past(set_i)) == ($past(flags_o) & ~$past(clr_i) & ~$past(set_i)));
endmodule

// File: rtl/dma_chan_tracker.sv
module dma_chan_tracker
  import dma_trk_pkg::*;
#(
  parameter int unsigned SZW  = 8,
  parameter int unsigned IRQW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            chan_en_i,
  input  logic [SZW-1:0]  src_size_i,
  input  logic [SZW-1:0]  dst_size_i,
  input  logic [SZW-1:0]  cell_size_i,
  input  logic [IRQW-1:0] abort_num_i,
  input  logic            beat_i,
  input  logic            pat_match_i,
  input  logic            irq_valid_i,
  input  logic [IRQW-1:0] irq_num_i,
  input  logic            src_addr_err_i,
  input  logic            dst_addr_err_i,
  input  logic [7:0]      flag_clr_i,
  input  logic [7:0]      flag_en_i,
  output logic [7:0]      flags_o,
  output logic            irq_o,
  output logic            active_o,
  output logic [SZW-1:0]  src_ptr_o,
  output logic [SZW-1:0]  dst_ptr_o
);
  logic halt_q, active, abort_hit, pat_hit, beat_hit, cnt_clr;
  logic [SZW-1:0] blk_lim;
  logic [SZW-1:0] lim  [NCNT];
  logic [SZW-1:0] cnt  [NCNT];
  logic [NCNT-1:0] done, half;
  flags_t set;

  assign active    = chan_en_i && !halt_q;
  assign abort_hit = active && irq_valid_i && (irq_num_i == abort_num_i);
  assign pat_hit   = active && pat_match_i && !abort_hit;
  assign beat_hit  = active && beat_i && !abort_hit && !pat_match_i;
  assign blk_lim   = (src_size_i > dst_size_i) ? src_size_i : dst_size_i;
  assign cnt_clr   = !chan_en_i || abort_hit || pat_hit || done[C_BLK];

  assign lim[C_SRC]  = src_size_i;
  assign lim[C_DST]  = dst_size_i;
  assign lim[C_CELL] = cell_size_i;
  assign lim[C_BLK]  = blk_lim;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    dma_trk_cnt #(.W(SZW)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cnt_clr),
      .step_i  (beat_hit),
      .limit_i (lim[g]),
      .cnt_o   (cnt[g]),
      .done_o  (done[g]),
      .half_o  (half[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         halt_q <= 1'b0;
    else if (!chan_en_i) halt_q <= 1'b0;
    else if (abort_hit)  halt_q <= 1'b1;
  end

  always_comb begin
    set           = '0;
    set[F_SRC_DN] = done[C_SRC];
    set[F_SRC_HF] = half[C_SRC];
    set[F_DST_DN] = done[C_DST];
    set[F_DST_HF] = half[C_DST];
    set[F_BLK]    = done[C_BLK] || pat_hit;
    set[F_CELL]   = done[C_CELL];
    set[F_ABORT]  = abort_hit;
    set[F_ADDR]   = src_addr_err_i || dst_addr_err_i;
  end

  dma_trk_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set),
    .clr_i   (flag_clr_i),
    .en_i    (flag_en_i),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );

  assign active_o  = active;
  assign src_ptr_o = cnt[C_SRC];
  assign dst_ptr_o = cnt[C_DST];

  // R9
  abort_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_hit |=> !active_o && src_ptr_o == '0 && dst_ptr_o == '0);
  // R9
  halt_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && !active_o |=> src_ptr_o == '0 && dst_ptr_o == '0);
  // R10
  addr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_addr_err_i || dst_addr_err_i |=> flags_o[F_ADDR]);
  // R11
  disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> src_ptr_o == '0 && dst_ptr_o == '0);
  // R12
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flags_o != '0);
endmodule

// File: tb/sim_dma_chan_tracker.sv
`timescale 1ns/1ps
module sim_dma_chan_tracker;
  localparam int SZW = 8, IRQW = 6;
  logic clk = 0, rst_ni = 0;
  logic chan_en = 0, beat = 0, pat = 0, irq_v = 0, serr = 0, derr = 0;
  logic [SZW-1:0] ss = 1, ds = 1, cs = 1;
  logic [IRQW-1:0] anum = 0, inum = 0;
  logic [7:0] clr = 0, en = 0;
  logic [7:0] flags; logic irq, active;
  logic [SZW-1:0] sptr, dptr;
  int checks = 0, errors = 0;
  int m_s = 0, m_d = 0, m_c = 0, m_b = 0; bit m_halt = 0; logic [7:0] m_f = 0;

  always #2 clk = ~clk;

  dma_chan_tracker #(.SZW(SZW), .IRQW(IRQW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .chan_en_i(chan_en), .src_size_i(ss),
    .dst_size_i(ds), .cell_size_i(cs), .abort_num_i(anum), .beat_i(beat),
    .pat_match_i(pat), .irq_valid_i(irq_v), .irq_num_i(inum),
    .src_addr_err_i(serr), .dst_addr_err_i(derr), .flag_clr_i(clr),
    .flag_en_i(en), .flags_o(flags), .irq_o(irq), .active_o(active),
    .src_ptr_o(sptr), .dst_ptr_o(dptr));

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Reference model of one clock edge from the requirements
  task automatic model_step();
    bit act, ab, pm, bt, blkd;
    logic [7:0] set;
    int ns, nd, nc, nb, blk;
    act = chan_en && !m_halt;
    ab  = act && irq_v && (inum == anum);
    pm  = act && pat && !ab;
    bt  = act && beat && !ab && !pat;
    set = '0; blkd = 0;
    ns = m_s; nd = m_d; nc = m_c; nb = m_b;
    blk = (ss > ds) ? int'(ss) : int'(ds);
    if (serr || derr) set[0] = 1;
    if (ab) set[1] = 1;
    if (pm) set[3] = 1;
    if (bt) begin
      ns = m_s + 1; nd = m_d + 1; nc = m_c + 1; nb = m_b + 1;
      if (ss / 2 != 0 && ns == ss / 2) set[6] = 1;
      if (ds / 2 != 0 && nd == ds / 2) set[4] = 1;
      if (ns == ss) begin set[7] = 1; ns = 0; end
      if (nd == ds) begin set[5] = 1; nd = 0; end
      if (nc == cs) begin set[2] = 1; nc = 0; end
      if (nb == blk) begin set[3] = 1; blkd = 1; end
    end
    if (!chan_en || ab || pm || blkd) begin ns = 0; nd = 0; nc = 0; nb = 0; end
    if (!chan_en) m_halt = 0; else if (ab) m_halt = 1;
    m_s = ns; m_d = nd; m_c = nc; m_b = nb;
    m_f = (m_f & ~clr) | set;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #1;
    chk("R2 flags", flags, m_f);
    chk("R3 src_ptr", sptr, m_s);
    chk("R5 dst_ptr", dptr, m_d);
    chk("R9 active", active, chan_en && !m_halt);
    chk("R12 irq", irq, |(m_f & en));
  endtask

  task automatic idle();
    beat = 0; pat = 0; irq_v = 0; serr = 0; derr = 0; clr = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    // R1 during reset
    chk("R1 flags in reset", flags, 0);
    chk("R1 irq in reset", irq, 0);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    chk("R1 flags after reset", flags, 0);
    chk("R1 src_ptr after reset", sptr, 0);
    chk("R1 dst_ptr after reset", dptr, 0);

    // R6 R4 R8: src 6, dst 4, cell 3, six beats -> all progress flags
    en = 8'hff; ss = 6; ds = 4; cs = 3; anum = 5; chan_en = 1;
    idle(); cyc();
    beat = 1;
    repeat (6) cyc();
    chk("R6 block after max size beats", flags, 8'hfc);
    chk("R6 pointers reset at block", sptr + dptr, 0);
    chk("R12 irq with all enabled", irq, 1);
    idle(); en = 8'h00; cyc();
    chk("R12 irq masked", irq, 0);

    // R4 size 1: no half flags
    clr = 8'hff; cyc(); idle();
    ss = 1; ds = 1; cs = 1; beat = 1; cyc(); idle();
    chk("R4 size one no half", flags, 8'hac);

    // R2 set beats clear in same cycle
    clr = 8'hff; serr = 1; cyc(); idle();
    chk("R2 set wins over clear", flags, 8'h01);
    clr = 8'h01; cyc(); idle();
    chk("R2 write one clears", flags, 8'h00);

    // R7 pattern match with beat in same cycle
    ss = 8; ds = 8; cs = 8; beat = 1; repeat (3) cyc();
    pat = 1; cyc(); idle();
    chk("R7 pattern sets block", flags[3], 1);
    chk("R7 pattern resets src", sptr, 0);

    // R9 abort, later beats ignored, R11 re-enable
    clr = 8'hff; cyc(); idle();
    beat = 1; cyc(); irq_v = 1; inum = 5; cyc(); idle();
    chk("R9 abort flag", flags[1], 1);
    chk("R9 inactive after abort", active, 0);
    beat = 1; pat = 1; repeat (3) cyc(); idle();
    chk("R9 beats ignored", sptr, 0);
    chk("R9 pattern ignored", flags[3], 0);
    chan_en = 0; cyc(); chan_en = 1; cyc();
    chk("R11 disable releases halt", active, 1);
    beat = 1; cyc(); idle();
    chk("R11 counting resumes", sptr, 1);

    // random episodes
    for (int ep = 0; ep < 120; ep++) begin
      idle(); chan_en = 0; cyc();
      ss = 1 + $urandom_range(0, 11);
      ds = 1 + $urandom_range(0, 11);
      cs = 1 + $urandom_range(0, 5);
      anum = $urandom_range(0, 7);
      chan_en = 1;
      for (int k = 0; k < 40; k++) begin
        beat  = ($urandom_range(0, 99) < 70);
        pat   = ($urandom_range(0, 99) < 2);
        irq_v = ($urandom_range(0, 99) < 6);
        inum  = $urandom_range(0, 7);
        serr  = ($urandom_range(0, 99) < 2);
        derr  = ($urandom_range(0, 99) < 2);
        clr   = ($urandom_range(0, 99) < 15) ? 8'($urandom) : 8'h00;
        en    = 8'($urandom);
        if ($urandom_range(0, 99) < 2) chan_en = ~chan_en;
        cyc();
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule